// File: doc/BRIEF.md
# Two-Wire Memory Transfer Sequencer

This block runs whole register and memory transfers over a two-wire serial bus. It sits above a byte-level bus engine and decides which engine command comes next: a condition (START, STOP or bus recovery) or a single byte sent or received. One request gives a 7-bit target address, a memory address of zero to `ADDR_BYTES` bytes, a byte count and an operation. The operation is a write, a read, or a probe that only checks whether the target answers.

Write bytes come in on a valid/ready port, and read bytes go out on another. Each transfer ends with a one-cycle `done` pulse. The pulse carries a status code and the number of write bytes the target refused. A read can turn around from its address phase with either a STOP followed by a START, or a repeated START alone. Memory address bits above the bytes that are sent can be folded into the target address under a mask. After reset the block asks the engine for a bus recovery sequence once, before it accepts any work.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the first engine command is recovery (op code 0). `txn_ready` stays low until that command completes.
- R2: The first byte after every START is the effective target address in bits 7..1. Bit 0 is 1 only in the read data phase and 0 otherwise. `txn_op` is encoded as 0 write, 1 read, and 2 or 3 probe.
- R3: The memory address is sent as exactly `txn_alen` bytes (0 to 4), most significant byte first.
- R4: If the target refuses any target-address byte, the block issues STOP and ends with status 1 (no response).
- R5: If the target refuses a memory address byte, the block issues STOP at once and ends with status 2 (address refused).
- R6: A read with a nonzero address length writes the address and then issues STOP and START, or only START when `cfg_rep_start` is 1. A read with zero address length sends the read-direction target byte straight after the first START.
- R7: A read issues `txn_len` byte reads. Only the last one carries `eng_last`=1, which means it is not acknowledged. The bytes leave on `rd_data` in order under `rd_valid`/`rd_ready`, and STOP follows.
- R8: A write sends `txn_len` bytes taken from `wr_data` in order. Each refused data byte adds one to `fail_cnt` and the transfer goes on. `fail_cnt` is valid with `done`.
- R9: The effective target address is `txn_dev` ORed with the low 7 bits of (`txn_maddr` >> 8*`txn_alen`) masked by `cfg_ovf_mask`.
- R10: A probe issues START, the write-direction target byte and STOP. It ends with status 0 if that byte was acknowledged and status 1 if it was not.
- R11: `done` is a one-cycle pulse in the cycle after a STOP command completes. Status codes are 0 OK, 1 no response and 2 address refused. A request is taken only while `txn_ready` is high.
- R12: Engine op codes are 0 recovery, 1 START, 2 STOP, 3 write byte (`eng_wdata`) and 4 read byte. `eng_req`, `eng_op` and `eng_wdata` stay stable until `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | Transfer request valid |
| txn_ready | output | 1 | Sequencer idle and able to take a request |
| txn_op | input | 2 | 0 write, 1 read, 2/3 probe |
| txn_dev | input | 7 | Target address |
| txn_maddr | input | ADDR_BYTES*8 | Memory address |
| txn_alen | input | clog2(ADDR_BYTES+1) | Memory address bytes to send |
| txn_len | input | LEN_W | Data byte count |
| cfg_rep_start | input | 1 | Read turnaround uses a repeated START only |
| cfg_ovf_mask | input | 7 | Mask of upper address bits folded into the target address |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write data valid |
| wr_ready | output | 1 | Write data taken |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | Read data taken |
| done | output | 1 | Transfer finished pulse |
| status | output | 2 | Completion status |
| fail_cnt | output | LEN_W | Refused write data bytes |
| eng_req | output | 1 | Engine command request |
| eng_op | output | 3 | Engine command code |
| eng_wdata | output | 8 | Byte to send |
| eng_last | output | 1 | Read byte is the last one (not acknowledged) |
| eng_done | input | 1 | Engine command completed (one-cycle pulse) |
| eng_nack | input | 1 | Byte sent was not acknowledged |
| eng_rdata | input | 8 | Byte received |

## Verification
The bench uses the defaults `ADDR_BYTES`=4 and `LEN_W`=8. With these values every address length from zero to the full four bytes can be exercised. At length 4 the fold shift runs past the whole address, so the fold must contribute nothing. A bench-side engine model refuses bytes chosen by a per-transfer bit mask over the order in which bytes are written. This lets every abort point be reached: target byte, any address byte, the read-direction target byte, and any mix of data bytes. Random engine latency and random handshake stalls on both data ports check that commands and bytes are held until they are taken.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               txn_valid,
  output logic                               txn_ready,
  input  logic [1:0]                         txn_op,
  input  logic [6:0]                         txn_dev,
  input  logic [ADDR_BYTES*8-1:0]            txn_maddr,
  input  logic [$clog2(ADDR_BYTES+1)-1:0]    txn_alen,
  input  logic [LEN_W-1:0]                   txn_len,
  input  logic                               cfg_rep_start,
  input  logic [6:0]                         cfg_ovf_mask,
  input  logic [7:0]                         wr_data,
  input  logic                               wr_valid,
  output logic                               wr_ready,
  output logic [7:0]                         rd_data,
  output logic                               rd_valid,
  input  logic                               rd_ready,
  output logic                               done,
  output logic [1:0]                         status,
  output logic [LEN_W-1:0]                   fail_cnt,
  output logic                               eng_req,
  output logic [2:0]                         eng_op,
  output logic [7:0]                         eng_wdata,
  output logic                               eng_last,
  input  logic                               eng_done,
  input  logic                               eng_nack,
  input  logic [7:0]                         eng_rdata
);
  localparam int AW  = ADDR_BYTES * 8;
  localparam int ALW = $clog2(ADDR_BYTES + 1);

  localparam logic [2:0] CMD_RECOVER = 3'd0;
  localparam logic [2:0] CMD_START   = 3'd1;
  localparam logic [2:0] CMD_STOP    = 3'd2;
  localparam logic [2:0] CMD_WRITE   = 3'd3;
  localparam logic [2:0] CMD_READ    = 3'd4;

  localparam logic [1:0] STAT_OK     = 2'd0;
  localparam logic [1:0] STAT_NORESP = 2'd1;
  localparam logic [1:0] STAT_ADDRNK = 2'd2;

  typedef enum logic [3:0] {
    S_RECOV, S_IDLE, S_START, S_DEV, S_MADDR, S_TSTOP, S_RSTART,
    S_WFETCH, S_WBYTE, S_RBYTE, S_ROUT, S_STOP, S_FIN
  } state_t;

  state_t           st;
  logic             is_rd_q, is_probe_q, rep_q, dir_q;
  logic [6:0]       dev_q;
  logic [AW-1:0]    maddr_q;
  logic [ALW-1:0]   left_q;
  logic [LEN_W-1:0] cnt_q, fail_q;
  logic [7:0]       byte_q;
  logic [1:0]       stat_q;

  logic [6:0] dev_eff;
  logic [7:0] addr_byte;
  logic       cnt_zero, cnt_one;

  assign dev_eff   = txn_dev | (7'(txn_maddr >> (8 * 32'(txn_alen))) & cfg_ovf_mask);
  assign addr_byte = 8'(maddr_q >> (8 * (32'(left_q) - 1)));
  assign cnt_zero  = (cnt_q == '0);
  assign cnt_one   = (cnt_q == LEN_W'(1));

  assign txn_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_WFETCH);
  assign rd_valid  = (st == S_ROUT);
  assign rd_data   = byte_q;
  assign done      = (st == S_FIN);
  assign status    = stat_q;
  assign fail_cnt  = fail_q;
  assign eng_last  = (st == S_RBYTE) && cnt_one;

  always_comb begin
    eng_req   = 1'b1;
    eng_op    = CMD_RECOVER;
    eng_wdata = 8'd0;
    case (st)
      S_RECOV:           eng_op = CMD_RECOVER;
      S_START, S_RSTART: eng_op = CMD_START;
      S_TSTOP, S_STOP:   eng_op = CMD_STOP;
      S_DEV:    begin eng_op = CMD_WRITE; eng_wdata = {dev_q, dir_q}; end
      S_MADDR:  begin eng_op = CMD_WRITE; eng_wdata = addr_byte; end
      S_WBYTE:  begin eng_op = CMD_WRITE; eng_wdata = byte_q; end
      S_RBYTE:  eng_op = CMD_READ;
      default:  eng_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RECOV;
      is_rd_q    <= 1'b0;
      is_probe_q <= 1'b0;
      rep_q      <= 1'b0;
      dir_q      <= 1'b0;
      dev_q      <= '0;
      maddr_q    <= '0;
      left_q     <= '0;
      cnt_q      <= '0;
      fail_q     <= '0;
      byte_q     <= '0;
      stat_q     <= STAT_OK;
    end else begin
      case (st)
        S_RECOV: if (eng_done) st <= S_IDLE;
        S_IDLE: if (txn_valid) begin
          is_rd_q    <= (txn_op == 2'd1);
          is_probe_q <= txn_op[1];
          rep_q      <= cfg_rep_start;
          dir_q      <= (txn_op == 2'd1) && (txn_alen == '0);
          dev_q      <= dev_eff;
          maddr_q    <= txn_maddr;
          left_q     <= txn_alen;
          cnt_q      <= txn_len;
          fail_q     <= '0;
          stat_q     <= STAT_OK;
          st         <= S_START;
        end
        S_START: if (eng_done) st <= S_DEV;
        S_DEV: if (eng_done) begin
          if (eng_nack) begin
            stat_q <= STAT_NORESP;
            st     <= S_STOP;
          end else if (is_probe_q)   st <= S_STOP;
          else if (dir_q)            st <= cnt_zero ? S_STOP : S_RBYTE;
          else if (left_q != '0)     st <= S_MADDR;
          else                       st <= cnt_zero ? S_STOP : S_WFETCH;
        end
        S_MADDR: if (eng_done) begin
          if (eng_nack) begin
            stat_q <= STAT_ADDRNK;
            st     <= S_STOP;
          end else begin
            left_q <= left_q - ALW'(1);
            if (left_q == ALW'(1)) begin
              if (is_rd_q) st <= rep_q ? S_RSTART : S_TSTOP;
              else         st <= cnt_zero ? S_STOP : S_WFETCH;
            end
          end
        end
        S_TSTOP: if (eng_done) st <= S_RSTART;
        S_RSTART: if (eng_done) begin
          dir_q <= 1'b1;
          st    <= S_DEV;
        end
        S_WFETCH: if (wr_valid) begin
          byte_q <= wr_data;
          st     <= S_WBYTE;
        end
        S_WBYTE: if (eng_done) begin
          if (eng_nack) fail_q <= fail_q + LEN_W'(1);
          cnt_q <= cnt_q - LEN_W'(1);
          st    <= cnt_one ? S_STOP : S_WFETCH;
        end
        S_RBYTE: if (eng_done) begin
          byte_q <= eng_rdata;
          st     <= S_ROUT;
        end
        S_ROUT: if (rd_ready) begin
          cnt_q <= cnt_q - LEN_W'(1);
          st    <= cnt_one ? S_STOP : S_RBYTE;
        end
        S_STOP: if (eng_done) st <= S_FIN;
        S_FIN:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txn_ready,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       eng_req,
  input logic [2:0] eng_op,
  input logic [7:0] eng_wdata,
  input logic       eng_done
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_ready |-> !eng_req);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(eng_done && eng_op == 3'd2));

  // R12
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata)));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R8
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && (rd_valid || eng_req)));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txn_ready(txn_ready), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
  .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_done(eng_done)
);

// File: tb/test_i2c_xfer_seq.sv
module test_i2c_xfer_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  LOGN = 4096;

  logic       clk = 0, rst_n = 0;
  logic       txn_valid = 0, txn_ready;
  logic [1:0] txn_op = 0;
  logic [6:0] txn_dev = 0;
  logic [31:0] txn_maddr = 0;
  logic [2:0] txn_alen = 0;
  logic [7:0] txn_len = 0;
  logic       cfg_rep_start = 0;
  logic [6:0] cfg_ovf_mask = 0;
  logic [7:0] wr_data = 0;
  logic       wr_valid = 0, wr_ready;
  logic [7:0] rd_data;
  logic       rd_valid, rd_ready = 0;
  logic       done;
  logic [1:0] status;
  logic [7:0] fail_cnt;
  logic       eng_req, eng_last;
  logic [2:0] eng_op;
  logic [7:0] eng_wdata;
  logic       eng_done, eng_nack;
  logic [7:0] eng_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_seq i_i2c_xfer_seq (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_op(txn_op), .txn_dev(txn_dev), .txn_maddr(txn_maddr), .txn_alen(txn_alen),
    .txn_len(txn_len), .cfg_rep_start(cfg_rep_start), .cfg_ovf_mask(cfg_ovf_mask),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .status(status), .fail_cnt(fail_cnt),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_last(eng_last),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata));

  // engine model
  logic [2:0] log_op [LOGN];
  logic [7:0] log_b  [LOGN];
  int         log_n, wr_ord, rd_ord, wr_base, dly;
  logic [63:0] nack_mask = 0;
  logic        busy;
  logic [2:0]  cur_op;

  function automatic logic [7:0] rd_pat(int k);
    return 8'(k * 37 + 11);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 0; eng_done <= 0; eng_nack <= 0; eng_rdata <= 0;
      log_n <= 0; wr_ord <= 0; rd_ord <= 0; dly <= 0; cur_op <= 0;
    end else begin
      eng_done <= 0;
      if (busy) begin
        if (dly > 0) dly <= dly - 1;
        else begin
          busy <= 0; eng_done <= 1; eng_nack <= 0;
          if (cur_op == 3) begin
            eng_nack <= ((wr_ord - wr_base) < 64) ? nack_mask[wr_ord - wr_base] : 1'b0;
            wr_ord <= wr_ord + 1;
          end
          if (cur_op == 4) begin
            eng_rdata <= rd_pat(rd_ord);
            rd_ord <= rd_ord + 1;
          end
        end
      end else if (eng_req && !eng_done) begin
        busy <= 1; cur_op <= eng_op; dly <= int'($urandom % 3);
        if (log_n < LOGN) begin
          log_op[log_n] <= eng_op;
          log_b[log_n]  <= (eng_op == 3) ? eng_wdata : (eng_op == 4) ? {7'd0, eng_last} : 8'd0;
        end
        log_n <= log_n + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected model
  logic [2:0] exp_op [64];
  logic [7:0] exp_b  [64];
  int exp_n, exp_rdn, exp_stat, exp_fail;
  logic [7:0] wbuf [32];

  task automatic push(logic [2:0] op, logic [7:0] b);
    exp_op[exp_n] = op; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic build(int op, logic [6:0] dev, logic [31:0] ma, int alen, int len,
                       bit rep, logic [6:0] msk, logic [63:0] nm);
    logic [63:0] m64;
    logic [6:0]  de;
    int wo;
    bit stop_now;
    m64 = {32'd0, ma};
    de = dev | (7'(m64 >> (8 * alen)) & msk);
    exp_n = 0; exp_rdn = 0; exp_stat = 0; exp_fail = 0; wo = 0; stop_now = 0;
    push(1, 0);
    if (op >= 2) begin
      push(3, {de, 1'b0});
      exp_stat = nm[wo] ? 1 : 0;
      push(2, 0);
      return;
    end
    if (op == 0 || alen > 0) begin
      push(3, {de, 1'b0});
      if (nm[wo]) begin exp_stat = 1; push(2, 0); return; end
      wo++;
      for (int i = alen - 1; i >= 0; i--) begin
        push(3, 8'(m64 >> (8 * i)));
        if (nm[wo]) begin exp_stat = 2; push(2, 0); return; end
        wo++;
      end
    end
    if (op == 0) begin
      for (int i = 0; i < len; i++) begin
        push(3, wbuf[i]);
        if (nm[wo]) exp_fail++;
        wo++;
      end
      push(2, 0);
      return;
    end
    if (alen > 0) begin
      if (!rep) push(2, 0);
      push(1, 0);
    end
    push(3, {de, 1'b1});
    if (nm[wo]) begin exp_stat = 1; push(2, 0); return; end
    for (int i = 0; i < len; i++) begin
      push(4, {7'd0, i == len - 1});
      exp_rdn++;
    end
    push(2, 0);
    stop_now = 1;
  endtask

  task automatic run(string tag, int op, logic [6:0] dev, logic [31:0] ma, int alen,
                     int len, bit rep, logic [6:0] msk, logic [63:0] nm);
    int lbase, rbase, wi, ri, cyc;
    bit pend, fin, seq_ok;
    logic [7:0] got [32];
    int gstat, gfail;
    @(negedge clk);
    for (int i = 0; i < 32; i++) wbuf[i] = 8'($urandom);
    build(op, dev, ma, alen, len, rep, msk, nm);
    nack_mask = nm; wr_base = wr_ord; lbase = log_n; rbase = rd_ord;
    txn_op = 2'(op); txn_dev = dev; txn_maddr = ma; txn_alen = 3'(alen);
    txn_len = 8'(len); cfg_rep_start = rep; cfg_ovf_mask = msk;
    pend = 1; fin = 0; wi = 0; ri = 0; cyc = 0; gstat = -1; gfail = -1;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      if (cyc > 3000) begin chk(0, tag, "transfer timeout", cyc, 3000); break; end
      if (done) begin gstat = int'(status); gfail = int'(fail_cnt); fin = 1; end
      if (pend) begin txn_valid = 1; if (txn_ready) pend = 0; end
      else txn_valid = 0;
      if (op == 0 && wi < len) begin
        wr_valid = ($urandom % 4) != 0; wr_data = wbuf[wi];
        if (wr_valid && wr_ready) wi++;
      end else wr_valid = 0;
      rd_ready = ($urandom % 3) != 0;
      if (rd_valid && rd_ready) begin
        if (ri < 32) got[ri] = rd_data;
        ri++;
      end
    end
    txn_valid = 0; wr_valid = 0; rd_ready = 0;
    seq_ok = (log_n - lbase) == exp_n;
    for (int i = 0; i < exp_n && seq_ok; i++)
      if (log_op[lbase + i] != exp_op[i] || log_b[lbase + i] != exp_b[i]) seq_ok = 0;
    chk(seq_ok, tag, "engine command sequence length", log_n - lbase, exp_n);
    chk(gstat == exp_stat, {tag, " R11"}, "status", gstat, exp_stat);
    if (op == 0) chk(gfail == exp_fail, {tag, " R8"}, "fail_cnt", gfail, exp_fail);
    if (op == 1) begin
      chk(ri == exp_rdn, {tag, " R7"}, "read bytes delivered", ri, exp_rdn);
      for (int i = 0; i < ri && i < 32; i++)
        chk(got[i] == rd_pat(rbase + i), {tag, " R7"}, "read data", got[i], rd_pat(rbase + i));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      chk(0, "watchdog", "run did not finish", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    chk(done == 0, "R11", "done during reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    chk(txn_ready == 0, "R1", "txn_ready during recovery", txn_ready, 0);
    while (!txn_ready) @(negedge clk);
    chk(log_n == 1 && log_op[0] == 0, "R1", "recovery command issued first", log_n, 1);

    // directed corners
    run("R10 probe ack", 2, 7'h50, 0, 0, 0, 0, 0, 64'h0);
    run("R10 R4 probe nack", 3, 7'h51, 0, 0, 0, 0, 0, 64'h1);
    run("R4 write target nack", 0, 7'h22, 32'h1234, 2, 3, 0, 0, 64'h1);
    run("R5 write address nack", 0, 7'h22, 32'h00ABCDEF, 3, 3, 0, 0, 64'h4);
    run("R8 write data nacks", 0, 7'h33, 32'h0102, 2, 5, 0, 0, 64'h50);
    run("R6 read stop+start", 1, 7'h44, 32'h0A0B, 2, 3, 0, 0, 64'h0);
    run("R6 read repeated start", 1, 7'h44, 32'h0A0B, 2, 3, 1, 0, 64'h0);
    run("R6 read no address", 1, 7'h45, 0, 0, 4, 0, 0, 64'h0);
    run("R9 overflow fold", 1, 7'h50, 32'h00000356, 1, 2, 0, 7'h07, 64'h0);
    run("R9 overflow beyond width", 0, 7'h50, 32'hFFFFFFFF, 4, 1, 0, 7'h7F, 64'h0);
    run("R3 four byte address", 0, 7'h11, 32'hDEADBEEF, 4, 2, 0, 0, 64'h0);
    run("R4 read direction nack", 1, 7'h12, 32'h77, 1, 3, 1, 0, 64'h4);
    run("R7 read zero length", 1, 7'h13, 32'h5, 1, 0, 0, 0, 64'h0);
    run("R2 write zero length", 0, 7'h14, 0, 0, 0, 0, 0, 64'h0);

    // constrained random
    for (int t = 0; t < 60; t++) begin
      int op, alen, len;
      logic [63:0] nm;
      op = int'($urandom % 3);
      alen = int'($urandom % 5);
      len = int'($urandom % 7);
      nm = (($urandom % 3) == 0) ? (64'd1 << ($urandom % 10)) : 64'd0;
      run("R2 R3 random", op, 7'($urandom), $urandom, alen, len, 1'($urandom),
          (($urandom % 2) != 0) ? 7'($urandom) : 7'd0, nm);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule